// File: doc/BRIEF.md
# Delayed Read Transaction Queue

This block turns every inbound memory read into a delayed transaction. A read that arrives on the request port never completes at once: the block stores its address, command code and address parity in a free queue slot and tells the master that the read has been queued. It then sends the stored request upstream, tagged with the slot number, and waits for the upstream link to return data with the same tag.

What happens to returned data depends on a mode input. In conventional mode the data stays in its slot until the master retries. A retry is a request whose address and command match an occupied slot. A retry that finds the data present receives it, and the slot is freed. A retry that arrives while the data is still outstanding is told to retry again. In split-transaction mode nothing is matched. Each request takes a new slot, and returned data is pushed out on a completion port in the order the returns arrive. The slot is freed when the completion handshake finishes.

Top module: `delayed_read_queue`

## Requirements
- R1: In the first cycle after a synchronous reset, `req_ready` is 1 and `up_valid`, `rsp_valid`, `cpl_valid` and `ret_err` are all 0.
- R2: A request that is accepted and is not a conventional-mode retry takes the lowest-numbered free slot. That slot's index becomes its tag. In the cycle after the handshake, `rsp_valid` is 1 and `rsp_code` is 0 (queued).
- R3: While any slot holds a request that has not yet been issued, `up_valid` is 1. `up_tag` gives the lowest such slot, and `up_addr`, `up_cmd` and `up_par` carry that slot's stored values. Each slot is issued exactly once, on the cycle where `up_valid` and `up_ready` are both 1.
- R4: When all DEPTH slots are occupied, `req_ready` is 0. The one exception is conventional mode when the presented address and command match an occupied slot.
- R5: In conventional mode, an accepted request that matches a slot whose data has not yet returned gets `rsp_code` 1 (retry) and occupies no new slot.
- R6: In conventional mode, an accepted request that matches a slot holding returned data gets `rsp_code` 2 (data), with that data on `rsp_data`, and the slot becomes free.
- R7: In split mode, each return for a slot that is awaiting data yields exactly one completion. It carries the slot's tag, its stored address and the returned data. Completions come out in the order the returns arrived.
- R8: A completion is held stable while `cpl_ready` is 0. The completion's slot is freed when `cpl_valid` and `cpl_ready` are both 1.
- R9: A return whose tag names a slot that is not awaiting data is dropped. One cycle later, `ret_err` is 1 for exactly one cycle.
- R10: In split mode, a request with the same address and command as an occupied slot still takes a new slot and gets `rsp_code` 0.
- R11: In conventional mode, `cpl_valid` stays 0; returned data is delivered only through retries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_mode | input | 1 | 1 = split-transaction delivery, 0 = conventional retry delivery |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | CMD_W | Request command code |
| req_par | input | 1 | Address parity of the request |
| rsp_valid | output | 1 | Response to the request accepted in the previous cycle |
| rsp_code | output | 2 | 0 queued, 1 retry, 2 data |
| rsp_data | output | DATA_W | Read data when rsp_code is 2, otherwise 0 |
| up_valid | output | 1 | Stored request awaiting upstream issue |
| up_ready | input | 1 | Upstream link takes the request |
| up_tag | output | TAG_W | Slot index of the issued request |
| up_addr | output | ADDR_W | Stored address |
| up_cmd | output | CMD_W | Stored command code |
| up_par | output | 1 | Stored address parity |
| ret_valid | input | 1 | Upstream data return present |
| ret_tag | input | TAG_W | Slot the return belongs to |
| ret_data | input | DATA_W | Returned read data |
| ret_err | output | 1 | One-cycle pulse for a return that was dropped |
| cpl_valid | output | 1 | Split completion available |
| cpl_ready | input | 1 | Downstream takes the completion |
| cpl_tag | output | TAG_W | Slot of the completion |
| cpl_addr | output | ADDR_W | Address of the completed request |
| cpl_data | output | DATA_W | Completion data |

## Verification
The assertions assume that `split_mode` changes only while `rst` is high. They also assume that upstream returns arrive at most once per cycle. The bench respects both: it applies a fresh reset whenever it switches mode, and it raises `ret_valid` for a single cycle per return. Some returns are deliberately sent with stale or never-issued tags, and some requests are pushed against a full queue. These stay within the stated input assumptions, because dropping such returns and refusing such requests is defined behaviour. Every input changes on the falling clock edge.

// File: rtl/drq_pkg.sv
package drq_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_ISSUE = 2'd1,
        SLOT_WAIT  = 2'd2,
        SLOT_READY = 2'd3
    } slot_state_t;

    typedef enum logic [1:0] {
        RSP_QUEUED = 2'd0,
        RSP_RETRY  = 2'd1,
        RSP_DATA   = 2'd2
    } rsp_code_t;

    function automatic rsp_code_t lookup_code(input logic hit, input slot_state_t st);
        if (!hit)
            return RSP_QUEUED;
        return (st == SLOT_READY) ? RSP_DATA : RSP_RETRY;
    endfunction

    function automatic logic is_busy(input slot_state_t st);
        return st != SLOT_FREE;
    endfunction

endpackage

// File: rtl/drq_pick_low.sv
module drq_pick_low #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/drq_slot.sv
module drq_slot
    import drq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  logic [AW-1:0] alloc_addr,
    input  logic [CW-1:0] alloc_cmd,
    input  logic          alloc_par,
    input  logic          issue_ack,
    input  logic          fill,
    input  logic [DW-1:0] fill_data,
    input  logic          release_en,
    output slot_state_t   state,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] cmd,
    output logic          par,
    output logic [DW-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SLOT_FREE;
            addr  <= '0;
            cmd   <= '0;
            par   <= 1'b0;
            data  <= '0;
        end else if (release_en) begin
            state <= SLOT_FREE;
        end else if (alloc) begin
            state <= SLOT_ISSUE;
            addr  <= alloc_addr;
            cmd   <= alloc_cmd;
            par   <= alloc_par;
        end else if (issue_ack) begin
            state <= SLOT_WAIT;
        end else if (fill) begin
            state <= SLOT_READY;
            data  <= fill_data;
        end
    end

    // R2: a slot is claimed only while it is free
    a_r2_alloc_free: assert property (@(posedge clk) disable iff (rst)
        alloc |-> state == SLOT_FREE);
    // R3: a slot is issued upstream once, from the not-yet-issued state
    a_r3_single_issue: assert property (@(posedge clk) disable iff (rst)
        issue_ack |-> state == SLOT_ISSUE);
    // R9: data is written only into a slot awaiting it
    a_r9_fill_waiting: assert property (@(posedge clk) disable iff (rst)
        fill |-> state == SLOT_WAIT);
    // R6: only an occupied slot is released
    a_r6_release_busy: assert property (@(posedge clk) disable iff (rst)
        release_en |-> state != SLOT_FREE);
endmodule

// File: rtl/drq_tag_fifo.sv
module drq_tag_fifo #(
    parameter int DEPTH = 8,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [IW-1:0] push_tag,
    input  logic          pop,
    output logic          valid,
    output logic [IW-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [IW-1:0]   mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] cnt;

    assign valid = (cnt != '0);
    assign head  = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_tag;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop)
                rd_ptr <= bump(rd_ptr);
            if (push && !pop)
                cnt <= cnt + CNTW'(1);
            else if (pop && !push)
                cnt <= cnt - CNTW'(1);
        end
    end

    // R7: arrival-order buffer never overflows
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> cnt < CNTW'(DEPTH));
    // R8: a completion is taken only when one is present
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt != '0);
endmodule

// File: rtl/delayed_read_queue.sv
module delayed_read_queue
    import drq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              split_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic              req_par,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [DATA_W-1:0] rsp_data,
    output logic              up_valid,
    input  logic              up_ready,
    output logic [TAG_W-1:0]  up_tag,
    output logic [ADDR_W-1:0] up_addr,
    output logic [CMD_W-1:0]  up_cmd,
    output logic              up_par,
    input  logic              ret_valid,
    input  logic [TAG_W-1:0]  ret_tag,
    input  logic [DATA_W-1:0] ret_data,
    output logic              ret_err,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [ADDR_W-1:0] cpl_addr,
    output logic [DATA_W-1:0] cpl_data
);
    slot_state_t       st     [DEPTH];
    logic [ADDR_W-1:0] s_addr [DEPTH];
    logic [CMD_W-1:0]  s_cmd  [DEPTH];
    logic              s_par  [DEPTH];
    logic [DATA_W-1:0] s_data [DEPTH];

    logic [DEPTH-1:0] free_vec, hit_vec, issue_vec;
    logic [DEPTH-1:0] alloc_v, issue_v, fill_v, release_v;
    logic             free_found, hit_found;
    logic [TAG_W-1:0] free_idx, hit_idx;

    logic conv_hit, req_fire, alloc_fire, up_fire, ret_ok, cpl_fire;
    slot_state_t hit_st, ret_st;
    rsp_code_t   code_next;

    logic              rsp_valid_q, ret_err_q;
    rsp_code_t         rsp_code_q;
    logic [DATA_W-1:0] rsp_data_q;

    // per-slot storage and control
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign free_vec[g]  = (st[g] == SLOT_FREE);
        assign issue_vec[g] = (st[g] == SLOT_ISSUE);
        assign hit_vec[g]   = is_busy(st[g]) && (s_addr[g] == req_addr)
                              && (s_cmd[g] == req_cmd);

        assign alloc_v[g]   = alloc_fire && (free_idx == TAG_W'(g));
        assign issue_v[g]   = up_fire && (up_tag == TAG_W'(g));
        assign fill_v[g]    = ret_ok && (ret_tag == TAG_W'(g));
        assign release_v[g] = (cpl_fire && (cpl_tag == TAG_W'(g)))
                            || (req_fire && conv_hit && (hit_idx == TAG_W'(g))
                                && (st[g] == SLOT_READY));

        drq_slot #(.AW(ADDR_W), .CW(CMD_W), .DW(DATA_W)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .alloc      (alloc_v[g]),
            .alloc_addr (req_addr),
            .alloc_cmd  (req_cmd),
            .alloc_par  (req_par),
            .issue_ack  (issue_v[g]),
            .fill       (fill_v[g]),
            .fill_data  (ret_data),
            .release_en (release_v[g]),
            .state      (st[g]),
            .addr       (s_addr[g]),
            .cmd        (s_cmd[g]),
            .par        (s_par[g]),
            .data       (s_data[g])
        );
    end

    drq_pick_low #(.N(DEPTH), .IW(TAG_W)) u_pick_free (
        .vec (free_vec), .found (free_found), .idx (free_idx)
    );
    drq_pick_low #(.N(DEPTH), .IW(TAG_W)) u_pick_hit (
        .vec (hit_vec), .found (hit_found), .idx (hit_idx)
    );
    drq_pick_low #(.N(DEPTH), .IW(TAG_W)) u_pick_issue (
        .vec (issue_vec), .found (up_valid), .idx (up_tag)
    );

    // request side
    assign conv_hit   = !split_mode && hit_found;
    assign req_ready  = conv_hit || free_found;
    assign req_fire   = req_valid && req_ready;
    assign alloc_fire = req_fire && !conv_hit;
    assign hit_st     = st[hit_idx];
    assign code_next  = lookup_code(conv_hit, hit_st);

    // upstream issue side
    assign up_addr = s_addr[up_tag];
    assign up_cmd  = s_cmd[up_tag];
    assign up_par  = s_par[up_tag];
    assign up_fire = up_valid && up_ready;

    // upstream return side
    assign ret_st = st[ret_tag];
    assign ret_ok = ret_valid && (ret_st == SLOT_WAIT);

    // split completion ordering
    drq_tag_fifo #(.DEPTH(DEPTH), .IW(TAG_W)) u_order (
        .clk      (clk),
        .rst      (rst),
        .push     (ret_ok && split_mode),
        .push_tag (ret_tag),
        .pop      (cpl_fire),
        .valid    (cpl_valid),
        .head     (cpl_tag)
    );
    assign cpl_addr = s_addr[cpl_tag];
    assign cpl_data = s_data[cpl_tag];
    assign cpl_fire = cpl_valid && cpl_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_code_q  <= RSP_QUEUED;
            rsp_data_q  <= '0;
            ret_err_q   <= 1'b0;
        end else begin
            rsp_valid_q <= req_fire;
            ret_err_q   <= ret_valid && !ret_ok;
            if (req_fire) begin
                rsp_code_q <= code_next;
                rsp_data_q <= (code_next == RSP_DATA) ? s_data[hit_idx] : '0;
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_code  = rsp_code_q;
    assign rsp_data  = rsp_data_q;
    assign ret_err   = ret_err_q;

    // R2: every response answers a handshake one cycle earlier
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready));
    // R9: an error pulse always follows a return
    a_r9_err_after_ret: assert property (@(posedge clk) disable iff (rst)
        ret_err |-> $past(ret_valid));
    // R8: a stalled completion keeps its tag and data
    a_r8_cpl_hold: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !cpl_ready) |=> cpl_valid && $stable(cpl_tag) && $stable(cpl_data));
    // R11: conventional mode never offers a completion
    a_r11_no_cpl_conv: assert property (@(posedge clk) disable iff (rst)
        !split_mode |-> !cpl_valid);
endmodule

// File: tb/sim_delayed_read_queue.sv
module sim_delayed_read_queue;
    localparam int DEPTH = 8;
    localparam int AW = 32;
    localparam int CW = 4;
    localparam int DW = 32;
    localparam int TW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1, split_mode = 1'b0;
    logic req_valid = 1'b0, req_par = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_cmd = '0;
    logic up_ready = 1'b1, ret_valid = 1'b0, cpl_ready = 1'b1;
    logic [TW-1:0] ret_tag = '0;
    logic [DW-1:0] ret_data = '0;

    logic req_ready, rsp_valid, up_valid, up_par, ret_err, cpl_valid;
    logic [1:0] rsp_code;
    logic [DW-1:0] rsp_data, cpl_data;
    logic [TW-1:0] up_tag, cpl_tag;
    logic [AW-1:0] up_addr, cpl_addr;
    logic [CW-1:0] up_cmd;

    delayed_read_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .CMD_W(CW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .split_mode(split_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_cmd(req_cmd), .req_par(req_par),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
        .up_valid(up_valid), .up_ready(up_ready), .up_tag(up_tag),
        .up_addr(up_addr), .up_cmd(up_cmd), .up_par(up_par),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data), .ret_err(ret_err),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_tag(cpl_tag),
        .cpl_addr(cpl_addr), .cpl_data(cpl_data)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 free, 1 not issued, 2 awaiting data, 3 data held
    int            m_st   [DEPTH];
    logic [AW-1:0] m_addr [DEPTH];
    logic [CW-1:0] m_cmd  [DEPTH];
    logic [DW-1:0] m_data [DEPTH];
    int            m_cq[$];
    int            o_st   [DEPTH];
    bit            m_rsp_v = 0, m_err = 0;
    int            m_rsp_code = 0;
    logic [DW-1:0] m_rsp_data = '0;

    function automatic int f_first(input int want);
        for (int i = 0; i < DEPTH; i++) if (m_st[i] == want) return i;
        return -1;
    endfunction
    function automatic int f_hit();
        if (split_mode) return -1;
        for (int i = 0; i < DEPTH; i++)
            if (m_st[i] != 0 && m_addr[i] == req_addr && m_cmd[i] == req_cmd) return i;
        return -1;
    endfunction
    function automatic bit f_ready();
        return (f_hit() >= 0) || (f_first(0) >= 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) m_st[i] = 0;
            m_cq.delete();
            m_rsp_v = 0; m_err = 0; m_rsp_code = 0; m_rsp_data = '0;
        end else begin
            int hit, fr, iss;
            bit rdy, cv;
            hit = f_hit(); fr = f_first(0); iss = f_first(1); rdy = f_ready();
            cv = split_mode && (m_cq.size() > 0);
            for (int i = 0; i < DEPTH; i++) o_st[i] = m_st[i];
            if (iss >= 0 && up_ready) m_st[iss] = 2;
            if (cv && cpl_ready) begin
                m_st[m_cq[0]] = 0;
                void'(m_cq.pop_front());
            end
            m_err = 0;
            if (ret_valid) begin
                if (o_st[ret_tag] == 2) begin
                    m_st[ret_tag] = 3;
                    m_data[ret_tag] = ret_data;
                    if (split_mode) m_cq.push_back(int'(ret_tag));
                end else m_err = 1;
            end
            m_rsp_v = req_valid && rdy;
            if (m_rsp_v) begin
                if (hit >= 0) begin
                    if (o_st[hit] == 3) begin
                        m_rsp_code = 2; m_rsp_data = m_data[hit]; m_st[hit] = 0;
                    end else begin
                        m_rsp_code = 1; m_rsp_data = '0;
                    end
                end else begin
                    m_st[fr] = 1; m_addr[fr] = req_addr; m_cmd[fr] = req_cmd;
                    m_rsp_code = 0; m_rsp_data = '0;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always begin
        @(negedge clk);
        #3;
        if (!rst) begin
            int iss;
            iss = f_first(1);
            chk(req_ready == f_ready(), "R4", "req_ready", req_ready, f_ready());
            chk(up_valid == (iss >= 0), "R3", "up_valid", up_valid, iss >= 0);
            if (up_valid && iss >= 0) begin
                chk(up_tag == iss[TW-1:0], "R3", "up_tag", up_tag, iss);
                chk(up_addr == m_addr[iss], "R3", "up_addr", up_addr, m_addr[iss]);
            end
            chk(rsp_valid == m_rsp_v, "R2", "rsp_valid", rsp_valid, m_rsp_v);
            if (rsp_valid && m_rsp_v) begin
                if (m_rsp_code == 0)
                    chk(rsp_code == 2'd0, "R2", "rsp_code", rsp_code, m_rsp_code);
                else if (m_rsp_code == 1)
                    chk(rsp_code == 2'd1, "R5", "rsp_code", rsp_code, m_rsp_code);
                else begin
                    chk(rsp_code == 2'd2, "R6", "rsp_code", rsp_code, m_rsp_code);
                    chk(rsp_data == m_rsp_data, "R6", "rsp_data", rsp_data, m_rsp_data);
                end
            end
            chk(ret_err == m_err, "R9", "ret_err", ret_err, m_err);
            if (!split_mode)
                chk(cpl_valid == 1'b0, "R11", "cpl_valid", cpl_valid, 0);
            else begin
                chk(cpl_valid == (m_cq.size() > 0), "R7", "cpl_valid", cpl_valid, m_cq.size() > 0);
                if (cpl_valid && m_cq.size() > 0) begin
                    chk(cpl_tag == m_cq[0][TW-1:0], "R7", "cpl_tag", cpl_tag, m_cq[0]);
                    chk(cpl_data == m_data[m_cq[0]], "R8", "cpl_data", cpl_data, m_data[m_cq[0]]);
                    chk(cpl_addr == m_addr[m_cq[0]], "R7", "cpl_addr", cpl_addr, m_addr[m_cq[0]]);
                end
            end
        end
    end

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst = 1'b1; split_mode = mode;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #3;
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(up_valid == 1'b0, "R1", "up_valid", up_valid, 0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        chk(cpl_valid == 1'b0, "R1", "cpl_valid", cpl_valid, 0);
        chk(ret_err == 1'b0, "R1", "ret_err", ret_err, 0);
    endtask

    task automatic do_req(input logic [AW-1:0] a, input logic [CW-1:0] c, input logic p);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_cmd = c; req_par = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_ret(input int t, input logic [DW-1:0] d);
        @(negedge clk);
        ret_valid = 1'b1; ret_tag = t[TW-1:0]; ret_data = d;
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        finish_run();
    end

    initial begin
        // conventional mode
        do_reset(1'b0);
        do_req(32'h1000, 4'h6, 1'b1);            // R2 slot 0
        do_req(32'h2000, 4'h6, 1'b0);            // slot 1
        do_req(32'h3000, 4'h6, 1'b1);            // slot 2
        idle(3);
        do_req(32'h1000, 4'h6, 1'b1);            // R5 retry pending
        do_ret(1, 32'hB0B0_0001);
        idle(1);
        do_req(32'h2000, 4'h6, 1'b0);            // R6 data, frees slot 1
        do_ret(5, 32'hDEAD);                     // R9 never allocated
        do_ret(1, 32'hDEAD);                     // R9 already freed
        for (int i = 0; i < 6; i++)
            do_req(32'h4000 + 32'(i) * 32'h100, 4'h6, 1'b0);
        idle(3);
        do_req(32'h9000, 4'h6, 1'b0);            // R4 full, refused
        do_req(32'h1000, 4'h6, 1'b1);            // R4 retry accepted while full
        do_ret(0, 32'hA0A0_0000);
        do_req(32'h1000, 4'h6, 1'b1);            // R6
        do_req(32'h9000, 4'h6, 1'b0);            // refills slot 0
        idle(3);
        for (int t = 0; t < DEPTH; t++) do_ret(t, 32'hC000 + 32'(t));
        do_req(32'h4300, 4'h6, 1'b0);
        do_req(32'h3000, 4'h6, 1'b1);
        idle(4);

        // split mode
        do_reset(1'b1);
        up_ready = 1'b0;
        do_req(32'h5000, 4'h6, 1'b0);
        do_req(32'h5000, 4'h6, 1'b0);            // R10 duplicate takes new slot
        #1;
        chk(rsp_code == 2'd0, "R10", "rsp_code", rsp_code, 0);
        idle(3);
        up_ready = 1'b1;
        idle(3);
        cpl_ready = 1'b0;
        do_ret(1, 32'h1111);                     // R7 arrival order 1 then 0
        do_ret(0, 32'h2222);
        idle(3);                                 // R8 stalled completion
        cpl_ready = 1'b1;
        idle(4);
        do_ret(3, 32'h3333);                     // R9 bad tag
        for (int i = 0; i < DEPTH; i++)
            do_req(32'h6000 + 32'(i) * 32'h10, 4'h7, 1'(i));
        do_req(32'h7000, 4'h7, 1'b0);            // R4 full in split mode
        idle(3);
        for (int t = DEPTH - 1; t >= 0; t--) begin
            cpl_ready = t[0];
            do_ret(t, 32'hE000 + 32'(t));
        end
        cpl_ready = 1'b1;
        idle(12);
        finish_run();
    end
endmodule